// File: doc/BRIEF.md
# Latched Cartridge Clock and Bank Selector

This block keeps a running calendar counter: seconds, minutes, hours and a 9-bit day number. A one-cycle tick enable advances it once per second. Software never reads the running counter. It reads a frozen snapshot, which it refreshes by writing a two-step handshake to a control region. The snapshot is exposed as five byte-wide clock registers: seconds, minutes, hours, the low day byte, and a high byte that holds day bit 8 and a sticky overflow flag.

Writes are decoded from the three upper address bits into four regions. The regions do four jobs:
- gate the external window on and off;
- pick a 7-bit program bank;
- steer the external window either to one of four RAM banks or to one clock register;
- drive the snapshot handshake.

On the read side, the block returns the selected snapshot byte. Otherwise it flags that the RAM path owns the read. The RAM array itself lives outside.

Top module: `latched_rtc_ctrl`

## Requirements
- R1: A write to region 0 (address bits [15:13] = 0) with data 0x0A opens the external window. Data 0x00 closes it. Any other value leaves the window unchanged.
- R2: A write to region 1 sets the program bank to data[6:0]. A value of zero is stored as one.
- R3: A write to region 2 with data 0–3 selects that RAM bank and leaves clock mode. Data 8–12 selects clock register (data − 8) and enters clock mode. Data 4–7 and 13–255 change nothing.
- R4: A write to region 3 with data 1 while unlatched copies the running counter into the snapshot and sets the latched flag. Data 0 while latched clears the flag. Every other write to region 3 leaves the snapshot unchanged, and ticks never alter the snapshot.
- R5: Clock register 0 is seconds (0–59), 1 is minutes (0–59), 2 is hours (0–23) and 3 is day bits [7:0]. Each counter carries into the next on the tick in which it wraps.
- R6: Clock register 4 holds day bit 8 in bit 0 and the overflow flag in bit 7; its other bits read 0. The day count wraps from 511 to 0 on the same tick that sets the overflow flag. The flag never clears except by reset.
- R7: After reset, the program bank is 1, the RAM bank is 0, the window is closed, clock mode is off, the selected register is 0, the latched flag is clear and every counter and snapshot register is zero.
- R8: With the window closed, rdData is 0xFF and ramPath is 0. With the window open in clock mode, rdData is the selected snapshot register and ramPath is 0. With the window open outside clock mode, ramPath is 1 and rdData is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrAddrHi | input | 3 | Address bits [15:13] of the write |
| wrData | input | 8 | Write data |
| secTick | input | 1 | One-second advance enable |
| rdData | output | 8 | Read data for the external window |
| ramPath | output | 1 | High when the read belongs to external RAM |
| romBank | output | ROM_W | Selected program bank |
| ramBank | output | RAM_W | Selected RAM bank |

## Verification
The assertions check these on every cycle:
- the window close and the program-bank zero substitution;
- that out-of-range selector values change nothing;
- that the read byte holds still in any cycle without a write, so ticks never leak into the snapshot;
- that the overflow flag, once set, stays set.

Only the bench scenarios can show the counting itself. These cover:
- carries from seconds through days after tens of thousands of ticks;
- the exact tick at which day 511 wraps to 0 with the flag rising;
- that a repeated 1 while latched does not refresh the snapshot.

A second instance with short counter limits reaches the day wrap within the run.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DAY_W = 9;
  localparam int REG_COUNT = 5;
  localparam int SEL_W = 3;

  typedef enum logic [2:0] {
    RGN_ENABLE = 3'd0,
    RGN_ROMSEL = 3'd1,
    RGN_SELECT = 3'd2,
    RGN_LATCH  = 3'd3
  } region_e;

  typedef struct packed {
    logic snapNow;
    logic advance;
  } ctrl_strobe_t;
endpackage

// File: rtl/rtc_wrap_cnt.sv
module rtc_wrap_cnt #(
  parameter int MAX = 60,
  localparam int W = (MAX > 1) ? $clog2(MAX) : 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         wrapOut
);
  assign wrapOut = inc && (value == W'(MAX - 1));

  always_ff @(posedge clk) begin
    if (!rstN) value <= '0;
    else if (wrapOut) value <= '0;
    else if (inc) value <= value + W'(1);
  end
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int ROM_W = 7,
  parameter int RAM_BANKS = 4,
  localparam int RAM_W = $clog2(RAM_BANKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrAddrHi,
  input  logic [7:0]       wrData,
  input  logic             secTick,
  output ctrl_strobe_t     strobe,
  output logic [ROM_W-1:0] romBank,
  output logic [RAM_W-1:0] ramBank,
  output logic             winOpen,
  output logic             clockMode,
  output logic [SEL_W-1:0] regSel
);
  logic latched;
  logic selIsRam, selIsClock;

  assign selIsRam   = wrData < 8'(RAM_BANKS);
  assign selIsClock = (wrData >= 8'd8) && (wrData < 8'(8 + REG_COUNT));

  always_comb begin
    strobe.advance = secTick;
    strobe.snapNow = wrEn && (wrAddrHi == RGN_LATCH) && !latched && (wrData == 8'd1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      romBank   <= ROM_W'(1);
      ramBank   <= '0;
      winOpen   <= 1'b0;
      clockMode <= 1'b0;
      regSel    <= '0;
      latched   <= 1'b0;
    end else if (wrEn) begin
      case (wrAddrHi)
        RGN_ENABLE: begin
          if (wrData == 8'h0A) winOpen <= 1'b1;
          else if (wrData == 8'h00) winOpen <= 1'b0;
        end
        RGN_ROMSEL: begin
          romBank <= (wrData[ROM_W-1:0] == '0) ? ROM_W'(1) : wrData[ROM_W-1:0];
        end
        RGN_SELECT: begin
          if (selIsRam) begin
            ramBank   <= wrData[RAM_W-1:0];
            clockMode <= 1'b0;
          end else if (selIsClock) begin
            regSel    <= SEL_W'(wrData - 8'd8);
            clockMode <= 1'b1;
          end
        end
        RGN_LATCH: begin
          if (latched && wrData == 8'd0) latched <= 1'b0;
          else if (!latched && wrData == 8'd1) latched <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rtc_data.sv
module rtc_data
  import rtc_pkg::*;
#(
  parameter int SEC_MAX = 60,
  parameter int MIN_MAX = 60,
  parameter int HR_MAX  = 24,
  localparam int SEC_W = (SEC_MAX > 1) ? $clog2(SEC_MAX) : 1,
  localparam int MIN_W = (MIN_MAX > 1) ? $clog2(MIN_MAX) : 1,
  localparam int HR_W  = (HR_MAX > 1) ? $clog2(HR_MAX) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_strobe_t     strobe,
  input  logic             winOpen,
  input  logic             clockMode,
  input  logic [SEL_W-1:0] regSel,
  output logic [7:0]       rdData,
  output logic             ramPath
);
  logic [SEC_W-1:0] secVal;
  logic [MIN_W-1:0] minVal;
  logic [HR_W-1:0]  hrVal;
  logic             secWrap, minWrap, hrWrap;
  logic [DAY_W-1:0] dayVal;
  logic             dayOvf;
  logic [7:0]       snapReg [REG_COUNT];

  rtc_wrap_cnt #(.MAX(SEC_MAX)) u_sec (
    .clk(clk), .rstN(rstN), .inc(strobe.advance), .value(secVal), .wrapOut(secWrap));
  rtc_wrap_cnt #(.MAX(MIN_MAX)) u_min (
    .clk(clk), .rstN(rstN), .inc(secWrap), .value(minVal), .wrapOut(minWrap));
  rtc_wrap_cnt #(.MAX(HR_MAX)) u_hr (
    .clk(clk), .rstN(rstN), .inc(minWrap), .value(hrVal), .wrapOut(hrWrap));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dayVal <= '0;
      dayOvf <= 1'b0;
    end else if (hrWrap) begin
      if (dayVal == '1) begin
        dayVal <= '0;
        dayOvf <= 1'b1;
      end else begin
        dayVal <= dayVal + DAY_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) snapReg[i] <= '0;
    end else if (strobe.snapNow) begin
      snapReg[0] <= 8'(secVal);
      snapReg[1] <= 8'(minVal);
      snapReg[2] <= 8'(hrVal);
      snapReg[3] <= dayVal[7:0];
      snapReg[4] <= {dayOvf, 6'b0, dayVal[DAY_W-1]};
    end
  end

  always_comb begin
    ramPath = winOpen && !clockMode;
    rdData  = 8'hFF;
    if (winOpen && clockMode && (regSel < SEL_W'(REG_COUNT))) rdData = snapReg[regSel];
  end
endmodule

// File: rtl/latched_rtc_ctrl.sv
module latched_rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int SEC_MAX   = 60,
  parameter int MIN_MAX   = 60,
  parameter int HR_MAX    = 24,
  parameter int ROM_W     = 7,
  parameter int RAM_BANKS = 4,
  localparam int RAM_W = $clog2(RAM_BANKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrAddrHi,
  input  logic [7:0]       wrData,
  input  logic             secTick,
  output logic [7:0]       rdData,
  output logic             ramPath,
  output logic [ROM_W-1:0] romBank,
  output logic [RAM_W-1:0] ramBank
);
  ctrl_strobe_t     strobe;
  logic             winOpen, clockMode;
  logic [SEL_W-1:0] regSel;

  rtc_ctrl #(.ROM_W(ROM_W), .RAM_BANKS(RAM_BANKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddrHi(wrAddrHi), .wrData(wrData),
    .secTick(secTick), .strobe(strobe), .romBank(romBank), .ramBank(ramBank),
    .winOpen(winOpen), .clockMode(clockMode), .regSel(regSel));

  rtc_data #(.SEC_MAX(SEC_MAX), .MIN_MAX(MIN_MAX), .HR_MAX(HR_MAX)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .winOpen(winOpen),
    .clockMode(clockMode), .regSel(regSel), .rdData(rdData), .ramPath(ramPath));
endmodule

// File: rtl/latched_rtc_ctrl_chk.sv
module latched_rtc_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [2:0] wrAddrHi,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       ramPath,
  input logic [6:0] romBank,
  input logic [1:0] ramBank,
  input logic       dayOvf
);
  p_close_window_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddrHi == 3'd0 && wrData == 8'h00) |=> (rdData == 8'hFF && !ramPath));

  p_rom_bank_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddrHi == 3'd1) |=>
      (romBank == (($past(wrData[6:0]) == 7'd0) ? 7'd1 : $past(wrData[6:0]))));

  p_rom_nonzero_r2: assert property (@(posedge clk) disable iff (!rstN) romBank != 7'd0);

  p_select_ignored_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddrHi == 3'd2 && ((wrData >= 8'd4 && wrData < 8'd8) || wrData > 8'd12)) |=>
      ($stable(ramBank) && $stable(ramPath) && $stable(rdData)));

  p_snapshot_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(rdData));

  p_overflow_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    dayOvf |=> dayOvf);
endmodule

bind latched_rtc_ctrl latched_rtc_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddrHi(wrAddrHi), .wrData(wrData),
  .rdData(rdData), .ramPath(ramPath), .romBank(romBank), .ramBank(ramBank),
  .dayOvf(u_dp.dayOvf));

// File: tb/tb_latched_rtc_ctrl.sv
module tb_latched_rtc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 190000;

  typedef struct {
    int         kind;   // 0 rdData, 1 short-instance rdData, 2 romBank, 3 ramBank, 4 ramPath
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddrHi = '0;
  logic [7:0] wrData = '0;
  logic       secTick = 1'b0;
  logic [7:0] rdData, rdDataS;
  logic       ramPath, ramPathS;
  logic [6:0] romBank, romBankS;
  logic [1:0] ramBank, ramBankS;

  item_t q[$];
  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  latched_rtc_ctrl dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddrHi(wrAddrHi), .wrData(wrData),
    .secTick(secTick), .rdData(rdData), .ramPath(ramPath), .romBank(romBank),
    .ramBank(ramBank));

  // Short limits: 4 s/min, 4 min/h, 3 h/day, so one day is 48 ticks
  latched_rtc_ctrl #(.SEC_MAX(4), .MIN_MAX(4), .HR_MAX(3)) dutShort (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddrHi(wrAddrHi), .wrData(wrData),
    .secTick(secTick), .rdData(rdDataS), .ramPath(ramPathS), .romBank(romBankS),
    .ramBank(ramBankS));

  // Monitor: pops expectations and compares them with the live outputs
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        case (it.kind)
          0: act = rdData;
          1: act = rdDataS;
          2: act = 8'(romBank);
          3: act = 8'(ramBank);
          default: act = 8'(ramPath);
        endcase
        nChecks++;
        if (act !== it.exp) begin
          nFail++;
          $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expectVal(input int kind, input logic [7:0] exp, input string tag);
    item_t it;
    it.kind = kind;
    it.exp = exp;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wrReg(input logic [2:0] rgn, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrAddrHi = rgn;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      secTick = 1'b1;
    end
    @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic snap();
    wrReg(3'd3, 8'd0);
    wrReg(3'd3, 8'd1);
  endtask

  task automatic chkReg(input int idx, input logic [7:0] exp, input int kind, input string tag);
    wrReg(3'd2, 8'(8 + idx));
    expectVal(kind, exp, tag);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expectVal(2, 8'd1, "R7 reset program bank");
    expectVal(3, 8'd0, "R7 reset RAM bank");
    expectVal(0, 8'hFF, "R7/R8 reset window closed rdData");
    expectVal(4, 8'd0, "R7/R8 reset window closed ramPath");
    @(negedge clk);

    wrReg(3'd0, 8'h0A);
    expectVal(4, 8'd1, "R1/R8 window open, RAM path");
    expectVal(0, 8'hFF, "R8 RAM path rdData");

    wrReg(3'd1, 8'h00);
    expectVal(2, 8'd1, "R2 zero bank becomes one");
    wrReg(3'd1, 8'h85);
    expectVal(2, 8'd5, "R2 bank from data[6:0]");
    wrReg(3'd1, 8'h7F);
    expectVal(2, 8'h7F, "R2 bank 127");

    wrReg(3'd2, 8'd3);
    expectVal(3, 8'd3, "R3 RAM bank 3");
    wrReg(3'd2, 8'd5);
    expectVal(3, 8'd3, "R3 value 5 ignored");
    wrReg(3'd2, 8'd13);
    expectVal(3, 8'd3, "R3 value 13 ignored");
    expectVal(4, 8'd1, "R3 value 13 keeps RAM path");

    chkReg(0, 8'd0, 0, "R7 snapshot seconds zero after reset");
    expectVal(4, 8'd0, "R3/R8 clock mode clears ramPath");

    ticks(75);
    expectVal(0, 8'd0, "R4 snapshot unchanged by ticks");
    wrReg(3'd3, 8'd1);
    expectVal(0, 8'd15, "R4 first latch seconds");
    chkReg(1, 8'd1, 0, "R5 minutes after 75 ticks");
    chkReg(4, 8'd0, 0, "R6 upper day register zero");

    ticks(10);
    chkReg(0, 8'd15, 0, "R4 snapshot held while latched");
    wrReg(3'd3, 8'd1);
    expectVal(0, 8'd15, "R4 repeated 1 while latched ignored");
    snap();
    expectVal(0, 8'd25, "R4 relatch after 0 then 1");

    wrReg(3'd0, 8'h05);
    expectVal(0, 8'd25, "R1 other value leaves window open");
    wrReg(3'd0, 8'h00);
    expectVal(0, 8'hFF, "R1/R8 window closed rdData");
    expectVal(4, 8'd0, "R1/R8 window closed ramPath");
    wrReg(3'd0, 8'h0A);
    expectVal(0, 8'd25, "R1 reopen keeps clock register");

    // Advance to 24575 ticks: short instance at day 511, 2:03:03
    ticks(24575 - 85);
    snap();
    chkReg(0, 8'd3, 1, "R5 short seconds at day 511");
    chkReg(1, 8'd3, 1, "R5 short minutes at day 511");
    chkReg(2, 8'd2, 1, "R5 short hours at day 511");
    chkReg(3, 8'hFF, 1, "R5 short day low at 511");
    chkReg(4, 8'h01, 1, "R6 day bit 8 set, no overflow");
    chkReg(0, 8'd35, 0, "R5 seconds at 24575 ticks");
    chkReg(1, 8'd49, 0, "R5 minutes at 24575 ticks");
    chkReg(2, 8'd6, 0, "R5 hours at 24575 ticks");

    ticks(1);
    snap();
    chkReg(4, 8'h80, 1, "R6 wrap to day 0 sets overflow");
    chkReg(3, 8'h00, 1, "R6 day low zero after wrap");
    chkReg(0, 8'h00, 1, "R5 short seconds carry at wrap");

    // Advance to 90061 ticks: 1 day 1 h 1 min 1 s on the full instance
    ticks(90061 - 24576);
    snap();
    chkReg(0, 8'd1, 0, "R5 seconds after one day");
    chkReg(1, 8'd1, 0, "R5 minutes after one day");
    chkReg(2, 8'd1, 0, "R5 hours wrap into days");
    chkReg(3, 8'd1, 0, "R5 day low one");
    chkReg(4, 8'h00, 0, "R6 no overflow on full instance");
    chkReg(3, 8'h54, 1, "R6 short day low after wrap continues");
    chkReg(4, 8'h81, 1, "R6 overflow stays set while counting");
    chkReg(1, 8'd3, 1, "R5 short minutes at 90061");

    while (q.size() > 0) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG_CYCLES) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule